// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block sits between a simple request/ready host port and an external asynchronous static RAM. The RAM is 256K words of 16 bits. Its chip, write and output enables are active low, and it has one active-low enable per byte lane. The host presents a read or write request with an address, write data and a byte-lane mask. The controller accepts the request when it is ready and latches it. It then holds the memory strobes for a programmable number of clock cycles and drives the shared data pins through a tristate enable. For a read, it registers the returned word and hands it back with a one-cycle valid pulse.

Each access ends with one turnaround cycle in which every strobe is inactive. The controller turns its data drivers on only after the memory outputs have been turned off. It keeps them on until one cycle after the write strobe rises, so the memory commits stable data on that edge.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, ready_o is 1, rvalid_o is 0 and mem_ce_no, mem_we_no, mem_oe_no and both bits of mem_be_no are 1.
- R2: Whenever ready_o is 1 (idle), mem_ce_no is 1 (memory in standby).
- R3: A read holds mem_ce_no=0, mem_oe_no=0 and mem_we_no=1 for exactly RD_WAIT consecutive cycles, with the request address on mem_addr_o.
- R4: A write holds mem_ce_no=0 and mem_we_no=0 for exactly WR_WAIT consecutive cycles, and mem_oe_no stays 1 throughout.
- R5: Lane enables follow the request mask. req_be_i[0]=1 drives mem_be_no[0]=0 (data bits 7:0), and req_be_i[1]=1 drives mem_be_no[1]=0 (bits 15:8). A write leaves a memory lane whose mask bit is 0 unchanged.
- R6: A read returns its word on rdata_o with rvalid_o high for exactly one cycle, the cycle right after the last strobe cycle. Lanes whose mask bit is 0 read as zero.
- R7: The controller drives mem_dq_io only from one cycle after mem_we_no falls until one cycle after it rises, and never while mem_oe_no is 0. The data is therefore still driven at the rising edge of mem_we_no.
- R8: Each access is followed by exactly one cycle with all strobes at 1 and ready_o at 0. ready_o returns 2 cycles after the last strobe cycle.
- R9: While ready_o is 0, req_valid_i is ignored and starts no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Word address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Lane mask, bit0 low byte, bit1 high byte |
| ready_o | output | 1 | Idle; request accepted on this cycle's edge |
| rdata_o | output | 16 | Read data, unmasked lanes zero |
| rvalid_o | output | 1 | One-cycle read data valid pulse |
| mem_addr_o | output | 18 | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_be_no | output | 2 | Memory lane enables, active low |
| mem_dq_io | inout | 16 | Shared data bus |

## Verification
The bench counts strobe pulse widths at the pins. A wrong wait counter shows up as a read or write pulse that is one cycle short or long. It also checks latencies in cycles: a missing turnaround cycle would bring ready_o back one cycle early, and a late capture would move the rvalid_o pulse or return stale data. Partial-mask writes followed by full-word reads catch a lane enable that is wired to the wrong lane or inverted, because that corrupts the neighbouring byte. A request held during a busy access must leave memory untouched, which exposes a controller that accepts work while it is not ready. Dropping the drivers at the write-strobe edge makes the memory commit undriven data, and the read-back shows it.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_TURN = 2'd3
  } state_e;
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_WAIT = 3,
  parameter int WR_WAIT = 3
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   write_i,
  output state_e state_o,
  output logic   last_o
);
  localparam int MAX_W = (RD_WAIT > WR_WAIT) ? RD_WAIT : WR_WAIT;
  localparam int CNT_W = $clog2(MAX_W + 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim    = (state_q == ST_WR) ? CNT_W'(WR_WAIT - 1) : CNT_W'(RD_WAIT - 1);
  assign last_o = (state_q == ST_RD || state_q == ST_WR) && (cnt_q == lim);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = write_i ? ST_WR : ST_RD;
      ST_RD, ST_WR: if (last_o) state_d = ST_TURN;
      ST_TURN: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_d != state_q) cnt_q <= '0;
      else if (state_q == ST_RD || state_q == ST_WR) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/sram_ctrl_lane.sv
module sram_ctrl_lane #(
  parameter int LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              en_i,
  input  logic [LANE_W-1:0] dq_i,
  output logic [LANE_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rdata_o <= '0;
    else if (cap_i) rdata_o <= en_i ? dq_i : '0;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 18,
  parameter int DATA_W  = 16,
  parameter int RD_WAIT = 3,
  parameter int WR_WAIT = 3
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic                   req_write_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  input  logic [DATA_W-1:0]      req_wdata_i,
  input  logic [DATA_W/8-1:0]    req_be_i,
  output logic                   ready_o,
  output logic [DATA_W-1:0]      rdata_o,
  output logic                   rvalid_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic                   mem_ce_no,
  output logic                   mem_we_no,
  output logic                   mem_oe_no,
  output logic [DATA_W/8-1:0]    mem_be_no,
  inout  wire  [DATA_W-1:0]      mem_dq_io
);
  localparam int LANES = DATA_W / 8;

  state_e            state;
  logic              last, accept, active, dq_oe;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              wr_q;

  assign ready_o = (state == ST_IDLE);
  assign accept  = ready_o && req_valid_i;
  assign active  = (state == ST_RD) || (state == ST_WR);

  sram_ctrl_seq #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (accept),
    .write_i (req_write_i),
    .state_o (state),
    .last_o  (last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o <= '0;
      wdata_q    <= '0;
      be_q       <= '0;
      wr_q       <= 1'b0;
    end else if (accept) begin
      mem_addr_o <= req_addr_i;
      wdata_q    <= req_wdata_i;
      be_q       <= req_be_i;
      wr_q       <= req_write_i;
    end
  end

  // strobes decoded from registered state only
  assign mem_ce_no = !active;
  assign mem_we_no = !(state == ST_WR);
  assign mem_oe_no = !(state == ST_RD);
  assign mem_be_no = active ? ~be_q : '1;

  // drivers follow the write strobe by one cycle on both edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dq_oe <= 1'b0;
    else         dq_oe <= (state == ST_WR);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rvalid_o <= 1'b0;
    else         rvalid_o <= last && !wr_q;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mem_dq_io[8*i +: 8] = dq_oe ? wdata_q[8*i +: 8] : 8'bz;
    sram_ctrl_lane #(.LANE_W(8)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (last && (state == ST_RD)),
      .en_i    (be_q[i]),
      .dq_i    (mem_dq_io[8*i +: 8]),
      .rdata_o (rdata_o[8*i +: 8])
    );
  end
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int RD_WAIT = 3,
  parameter int WR_WAIT = 3
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ready_o,
  input logic rvalid_o,
  input logic mem_ce_no,
  input logic mem_we_no,
  input logic mem_oe_no,
  input logic dq_oe
);
  logic [7:0] oe_run, we_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_run <= '0;
      we_run <= '0;
    end else begin
      oe_run <= mem_oe_no ? 8'd0 : oe_run + 8'd1;
      we_run <= mem_we_no ? 8'd0 : we_run + 8'd1;
    end
  end

  a_r2_idle_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> mem_ce_no);
  a_r3_read_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_oe_no) |-> oe_run == 8'(RD_WAIT));
  a_r4_write_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> we_run == 8'(WR_WAIT));
  a_r4_oe_off_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);
  a_r7_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe |-> mem_oe_no);
  a_r7_hold_at_we_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> dq_oe);
  a_r6_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  a_r8_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> !ready_o && mem_we_no && mem_oe_no);
endmodule

bind sram_ctrl sram_ctrl_chk #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_o   (ready_o),
  .rvalid_o  (rvalid_o),
  .mem_ce_no (mem_ce_no),
  .mem_we_no (mem_we_no),
  .mem_oe_no (mem_oe_no),
  .dq_oe     (dq_oe)
);

// File: tb/sram_ctrl_tb.sv
module sram_ctrl_tb_top;
  localparam int RD_WAIT = 3;
  localparam int WR_WAIT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        ready, rvalid, ce_n, we_n, oe_n;
  logic [15:0] rdata;
  logic [17:0] maddr;
  logic [1:0]  be_n;
  wire  [15:0] dq;

  int total = 0, bad = 0;

  always #4 clk = ~clk;

  sram_ctrl #(.RD_WAIT(RD_WAIT), .WR_WAIT(WR_WAIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_be_i(req_be),
    .ready_o(ready), .rdata_o(rdata), .rvalid_o(rvalid), .mem_addr_o(maddr),
    .mem_ce_no(ce_n), .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_be_no(be_n),
    .mem_dq_io(dq)
  );

  // behavioural memory, low address bits only
  logic [15:0] mem [256];
  logic        rd_on;
  logic [1:0]  wlane;
  logic [7:0]  widx;
  assign rd_on = !ce_n && !oe_n && we_n;
  assign dq[7:0]  = (rd_on && !be_n[0]) ? mem[maddr[7:0]][7:0]  : 8'bz;
  assign dq[15:8] = (rd_on && !be_n[1]) ? mem[maddr[7:0]][15:8] : 8'bz;

  always @(negedge clk) if (!we_n) begin wlane <= ~be_n; widx <= maddr[7:0]; end
  always @(posedge we_n) begin
    if (wlane[0]) mem[widx][7:0]  <= dq[7:0];
    if (wlane[1]) mem[widx][15:8] <= dq[15:8];
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // issue one request; returns cycles until ready, strobe cycles and lane enables seen
  task automatic access(input logic wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] be, output int n_ready, output int n_strobe,
                        output logic [1:0] lanes, output logic [15:0] rd, output int n_rv);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    n_ready = 1; n_strobe = 0; lanes = 2'b00; rd = '0; n_rv = 0;
    while (!ready && n_ready < 50) begin
      if (wr ? !we_n : !oe_n) begin n_strobe++; lanes = ~be_n; end
      if (!ce_n) check("R3 addr", 32'(maddr), 32'(a));
      if (rvalid) begin rd = rdata; n_rv = n_ready; end
      @(negedge clk);
      n_ready++;
    end
  endtask

  task automatic t_reset;
    check("R1 ready", 32'(ready), 1);
    check("R1 rvalid", 32'(rvalid), 0);
    check("R1 strobes", {27'd0, ce_n, we_n, oe_n, be_n}, 32'h1f);
  endtask

  task automatic t_write_read;
    int nr, ns, nv; logic [1:0] ln; logic [15:0] rd;
    access(1'b1, 18'h3_0012, 16'hBEEF, 2'b11, nr, ns, ln, rd, nv);
    check("R4 write width", 32'(ns), 32'(WR_WAIT));
    check("R8 write ready latency", 32'(nr), 32'(WR_WAIT + 2));
    check("R2 idle standby", 32'(ce_n), 1);
    access(1'b0, 18'h3_0012, 16'h0, 2'b11, nr, ns, ln, rd, nv);
    check("R3 read width", 32'(ns), 32'(RD_WAIT));
    check("R6 read data", 32'(rd), 32'hBEEF);
    check("R6 rvalid cycle", 32'(nv), 32'(RD_WAIT + 1));
    check("R8 read ready latency", 32'(nr), 32'(RD_WAIT + 2));
    check("R6 rvalid cleared", 32'(rvalid), 0);
  endtask

  task automatic t_lanes;
    int nr, ns, nv; logic [1:0] ln; logic [15:0] rd;
    access(1'b1, 18'h0_0040, 16'h1234, 2'b11, nr, ns, ln, rd, nv);
    access(1'b1, 18'h0_0040, 16'hAAAA, 2'b01, nr, ns, ln, rd, nv);
    check("R5 lower lane strobe", 32'(ln), 32'b01);
    access(1'b1, 18'h0_0040, 16'h5555, 2'b10, nr, ns, ln, rd, nv);
    check("R5 upper lane strobe", 32'(ln), 32'b10);
    access(1'b0, 18'h0_0040, 16'h0, 2'b11, nr, ns, ln, rd, nv);
    check("R5 R7 masked writes", 32'(rd), 32'h55AA);
    access(1'b0, 18'h0_0040, 16'h0, 2'b01, nr, ns, ln, rd, nv);
    check("R6 upper zeroed", 32'(rd), 32'h00AA);
    check("R5 read lane strobe", 32'(ln), 32'b01);
    access(1'b0, 18'h0_0040, 16'h0, 2'b10, nr, ns, ln, rd, nv);
    check("R6 lower zeroed", 32'(rd), 32'h5500);
  endtask

  task automatic t_busy;
    int nr, ns, nv; logic [1:0] ln; logic [15:0] rd;
    access(1'b1, 18'h0_0077, 16'hC0DE, 2'b11, nr, ns, ln, rd, nv);
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h0_0010; req_wdata = 16'h1111; req_be = 2'b11;
    @(negedge clk);
    req_addr = 18'h0_0077; req_wdata = 16'hDEAD;   // offered while busy
    check("R9 busy ready low", 32'(ready), 0);
    @(negedge clk);
    check("R9 busy ready low", 32'(ready), 0);
    req_valid = 1'b0;
    while (!ready) @(negedge clk);
    access(1'b0, 18'h0_0077, 16'h0, 2'b11, nr, ns, ln, rd, nv);
    check("R9 busy request ignored", 32'(rd), 32'hC0DE);
    access(1'b0, 18'h0_0010, 16'h0, 2'b11, nr, ns, ln, rd, nv);
    check("R9 accepted request done", 32'(rd), 32'h1111);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_lanes();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule